// File: doc/BRIEF.md
# Hybrid Tiled Morton Address Generator

This block converts a two- or three-dimensional array index into a byte offset. The array is cut into fixed, power-of-two tiles. Inside a tile, elements are stored in transposed Morton order: the low bits of the per-axis indices are interleaved, with the first axis in the least significant position. The tiles themselves are stored one after another in column-major order. Because the tile shape is fixed, the position of an element inside its tile never depends on how large the array is.

Each index is split by bit slicing. The high bits form the tile number along that axis. The low bits form the position inside the tile. The caller supplies the number of tiles along the leading (first) axis. In 3-D mode the caller also supplies the number of tiles in one k-slice. The column-major tile number is then `ti + lead*tj + plane*tk`. It is scaled by the tile size in bytes. The Morton position is scaled by the element size.

The two products are computed in one registered stage and summed in a second registered stage. The block therefore accepts one index per cycle and has a fixed latency. A new request can be issued every clock, and results come out in the order the requests went in.

Top module: `hat_addr_gen`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `out_offset` is 0. An asserted `rst_n` clears `out_valid` at once, without waiting for a clock edge.
- R2: A request sampled with `in_valid`=1 on a rising edge produces exactly one result cycle. In that cycle `out_valid`=1, and it starts after the next rising edge (two edges in total). A cycle with `in_valid`=0 produces `out_valid`=0 two edges later.
- R3: In 2-D mode, the in-tile element number has index bit b of `idx_i` at bit 2b and bit b of `idx_j` at bit 2b+1, for b below TILE2_LOG2. With 4-byte elements and tile 0, index (3,5) gives offset 156 and index (6,5) gives offset 216.
- R4: In 3-D mode, bit b of `idx_i`, `idx_j` and `idx_k` goes to element-number bits 3b, 3b+1 and 3b+2, for b below TILE3_LOG2.
- R5: The element number is multiplied by 2^ELEM_LOG2 bytes. A whole tile occupies 2^(MORT_W+ELEM_LOG2) bytes, where MORT_W = max(2*TILE2_LOG2, 3*TILE3_LOG2). The defaults give 4-byte elements and 256-byte tiles.
- R6: In 2-D mode, the tile numbers are `idx_i >> TILE2_LOG2` and `idx_j >> TILE2_LOG2`. The offset is (ti + lead_tiles*tj) times the tile bytes, plus the scaled element number.
- R7: In 3-D mode, the tile numbers are each index shifted right by TILE3_LOG2. The tile index is ti + lead_tiles*tj + plane_tiles*tk.
- R8: `dim_sel`=0 selects 2-D mode and `dim_sel`=1 selects 3-D mode. In 2-D mode, `idx_k` and `plane_tiles` have no effect on the offset.
- R9: While no result is produced, `out_offset` keeps its last value, even when the inputs change with `in_valid`=0.
- R10: Requests on consecutive cycles each produce their own correct result on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| dim_sel | input | 1 | 0 = 2-D, 1 = 3-D |
| idx_i | input | IDX_W | Leading-axis index |
| idx_j | input | IDX_W | Second-axis index |
| idx_k | input | IDX_W | Third-axis index (3-D only) |
| lead_tiles | input | LEAD_W | Tile count along the leading axis |
| plane_tiles | input | PLANE_W | Tile count of one k-slice (3-D only) |
| out_valid | output | 1 | Result strobe |
| out_offset | output | OFF_W | Byte offset of the element |

## Verification
Some properties are checked by assertions on every cycle:
- the two-edge valid latency, both for a request and for an idle cycle;
- that the output holds its value between results;
- that the Morton position of each request carries exactly as many set bits as the in-tile index bits it came from.

The exact placement of those bits, the column-major tile arithmetic with the runtime strides, the 2-D mode ignoring `idx_k`, and the extreme-index products can only be shown by the bench. It compares each result against a model that places bits one at a time. It runs over hand-worked vectors, random 2-D and 3-D streams, and idle and reset scenarios.

// File: rtl/hat_addr_pkg.sv
package hat_addr_pkg;

  typedef enum logic {
    DIM2 = 1'b0,
    DIM3 = 1'b1
  } dim_mode_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/hat_tile_split.sv
module hat_tile_split
  import hat_addr_pkg::*;
#(
  parameter int IDX_W      = 16,
  parameter int TILE2_LOG2 = 3,
  parameter int TILE3_LOG2 = 2,
  parameter int TN_W       = 14,
  parameter int LOC_W      = 3
) (
  input  dim_mode_e                 mode,
  input  logic [2:0][IDX_W-1:0]     idx,
  output logic [2:0][TN_W-1:0]      tile,
  output logic [2:0][LOC_W-1:0]     loc
);

  // Power-of-two tile extents: div is a right shift, mod is a low slice.
  for (genvar a = 0; a < 3; a++) begin : g_axis
    logic [TN_W-1:0]  tile2, tile3;
    logic [LOC_W-1:0] loc2, loc3;

    assign tile2 = TN_W'(idx[a] >> TILE2_LOG2);
    assign tile3 = TN_W'(idx[a] >> TILE3_LOG2);
    assign loc2  = LOC_W'(idx[a][TILE2_LOG2-1:0]);
    assign loc3  = LOC_W'(idx[a][TILE3_LOG2-1:0]);

    if (a == 2) begin : g_third
      // Third axis exists only in 3-D mode.
      assign tile[a] = (mode == DIM3) ? tile3 : '0;
      assign loc[a]  = (mode == DIM3) ? loc3  : '0;
    end else begin : g_lead
      assign tile[a] = (mode == DIM3) ? tile3 : tile2;
      assign loc[a]  = (mode == DIM3) ? loc3  : loc2;
    end
  end

endmodule

// File: rtl/hat_morton_pack.sv
module hat_morton_pack
  import hat_addr_pkg::*;
#(
  parameter int TILE2_LOG2 = 3,
  parameter int TILE3_LOG2 = 2,
  parameter int LOC_W      = 3,
  parameter int MORT_W     = 6
) (
  input  dim_mode_e              mode,
  input  logic [2:0][LOC_W-1:0]  loc,
  output logic [MORT_W-1:0]      morton
);

  localparam int M2_W = 2 * TILE2_LOG2;
  localparam int M3_W = 3 * TILE3_LOG2;

  logic [M2_W-1:0] m2;
  logic [M3_W-1:0] m3;

  // 1-dilation: i on even bits, j on odd bits.
  for (genvar b = 0; b < TILE2_LOG2; b++) begin : g_d1
    assign m2[2*b]   = loc[0][b];
    assign m2[2*b+1] = loc[1][b];
  end

  // 2-dilation: i, j, k on bits 3b, 3b+1, 3b+2.
  for (genvar b = 0; b < TILE3_LOG2; b++) begin : g_d2
    assign m3[3*b]   = loc[0][b];
    assign m3[3*b+1] = loc[1][b];
    assign m3[3*b+2] = loc[2][b];
  end

  assign morton = (mode == DIM3) ? MORT_W'(m3) : MORT_W'(m2);

endmodule

// File: rtl/hat_tile_linear.sv
module hat_tile_linear #(
  parameter int TN_W            = 14,
  parameter int LEAD_W          = 16,
  parameter int PLANE_W         = 32,
  parameter int MORT_W          = 6,
  parameter int ELEM_LOG2       = 2,
  parameter int TILE_BYTES_LOG2 = 8,
  parameter int LIN_W           = 48,
  parameter int OFF_W           = 56
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [2:0][TN_W-1:0]   tile,
  input  logic [MORT_W-1:0]      morton,
  input  logic [LEAD_W-1:0]      lead_tiles,
  input  logic [PLANE_W-1:0]     plane_tiles,
  output logic                   out_valid,
  output logic [OFF_W-1:0]       out_offset
);

  localparam int PJ_W = LEAD_W + TN_W;
  localparam int PK_W = PLANE_W + TN_W;

  // Stage 1: stride products.
  logic              s1_valid_q, s1_valid_d;
  logic [TN_W-1:0]   s1_ti_q, s1_ti_d;
  logic [PJ_W-1:0]   s1_pj_q, s1_pj_d;
  logic [PK_W-1:0]   s1_pk_q, s1_pk_d;
  logic [MORT_W-1:0] s1_mort_q, s1_mort_d;

  // Stage 2: sum and scale.
  logic              s2_valid_q, s2_valid_d;
  logic [OFF_W-1:0]  s2_off_q, s2_off_d;
  logic [LIN_W-1:0]  lin_sum;

  always_comb begin
    s1_valid_d = in_valid;
    s1_ti_d    = s1_ti_q;
    s1_pj_d    = s1_pj_q;
    s1_pk_d    = s1_pk_q;
    s1_mort_d  = s1_mort_q;
    if (in_valid) begin
      s1_ti_d   = tile[0];
      s1_pj_d   = PJ_W'(lead_tiles) * PJ_W'(tile[1]);
      s1_pk_d   = PK_W'(plane_tiles) * PK_W'(tile[2]);
      s1_mort_d = morton;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_ti_q    <= '0;
      s1_pj_q    <= '0;
      s1_pk_q    <= '0;
      s1_mort_q  <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_ti_q    <= s1_ti_d;
      s1_pj_q    <= s1_pj_d;
      s1_pk_q    <= s1_pk_d;
      s1_mort_q  <= s1_mort_d;
    end
  end

  assign lin_sum = LIN_W'(s1_ti_q) + LIN_W'(s1_pj_q) + LIN_W'(s1_pk_q);

  always_comb begin
    s2_valid_d = s1_valid_q;
    s2_off_d   = s2_off_q;
    if (s1_valid_q) begin
      s2_off_d = (OFF_W'(lin_sum) << TILE_BYTES_LOG2)
               | (OFF_W'(s1_mort_q) << ELEM_LOG2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid_q <= 1'b0;
      s2_off_q   <= '0;
    end else begin
      s2_valid_q <= s2_valid_d;
      s2_off_q   <= s2_off_d;
    end
  end

  assign out_valid  = s2_valid_q;
  assign out_offset = s2_off_q;

  // R9: the result register only moves when stage 1 hands over a request.
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid_q |=> $stable(out_offset));

  // R10: a request in stage 1 always reaches the output on the next edge.
  p_stage_flow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid_q |=> out_valid);

endmodule

// File: rtl/hat_addr_gen.sv
module hat_addr_gen
  import hat_addr_pkg::*;
#(
  parameter int IDX_W      = 16,
  parameter int TILE2_LOG2 = 3,
  parameter int TILE3_LOG2 = 2,
  parameter int ELEM_LOG2  = 2,
  parameter int LEAD_W     = 16,
  parameter int PLANE_W    = 32,
  localparam int MORT_W          = max_i(2 * TILE2_LOG2, 3 * TILE3_LOG2),
  localparam int TILE_BYTES_LOG2 = MORT_W + ELEM_LOG2,
  localparam int TN_W            = IDX_W - min_i(TILE2_LOG2, TILE3_LOG2),
  localparam int LOC_W           = max_i(TILE2_LOG2, TILE3_LOG2),
  localparam int LIN_W           = max_i(LEAD_W, PLANE_W) + TN_W + 2,
  localparam int OFF_W           = LIN_W + TILE_BYTES_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               dim_sel,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [IDX_W-1:0]   idx_j,
  input  logic [IDX_W-1:0]   idx_k,
  input  logic [LEAD_W-1:0]  lead_tiles,
  input  logic [PLANE_W-1:0] plane_tiles,
  output logic               out_valid,
  output logic [OFF_W-1:0]   out_offset
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  dim_mode_e             mode;
  logic [2:0][IDX_W-1:0] idx;
  logic [2:0][TN_W-1:0]  tile;
  logic [2:0][LOC_W-1:0] loc;
  logic [MORT_W-1:0]     morton;

  assign mode = dim_mode_e'(dim_sel);
  assign idx  = {idx_k, idx_j, idx_i};

  hat_tile_split #(
    .IDX_W(IDX_W), .TILE2_LOG2(TILE2_LOG2), .TILE3_LOG2(TILE3_LOG2),
    .TN_W(TN_W), .LOC_W(LOC_W)
  ) split_i (
    .mode(mode), .idx(idx), .tile(tile), .loc(loc)
  );

  hat_morton_pack #(
    .TILE2_LOG2(TILE2_LOG2), .TILE3_LOG2(TILE3_LOG2),
    .LOC_W(LOC_W), .MORT_W(MORT_W)
  ) morton_i (
    .mode(mode), .loc(loc), .morton(morton)
  );

  // R3, R4: interleaving only moves bits, so the population count is kept.
  p_mort_bits2_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !dim_sel) |->
      ($countones(morton) == $countones(idx_i[TILE2_LOG2-1:0])
                           + $countones(idx_j[TILE2_LOG2-1:0])));

  p_mort_bits3_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && dim_sel) |->
      ($countones(morton) == $countones(idx_i[TILE3_LOG2-1:0])
                           + $countones(idx_j[TILE3_LOG2-1:0])
                           + $countones(idx_k[TILE3_LOG2-1:0])));

  hat_tile_linear #(
    .TN_W(TN_W), .LEAD_W(LEAD_W), .PLANE_W(PLANE_W), .MORT_W(MORT_W),
    .ELEM_LOG2(ELEM_LOG2), .TILE_BYTES_LOG2(TILE_BYTES_LOG2),
    .LIN_W(LIN_W), .OFF_W(OFF_W)
  ) linear_i (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid),
    .tile(tile), .morton(morton),
    .lead_tiles(lead_tiles), .plane_tiles(plane_tiles),
    .out_valid(out_valid), .out_offset(out_offset)
  );

  // R2: fixed two-edge latency at the ports, in both directions.
  p_lat_req_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> ##1 out_valid);

  p_lat_idle_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ##1 !out_valid);

endmodule

// File: tb/hat_addr_gen_tb.sv
`timescale 1ns/1ps
module hat_addr_gen_tb_top;

  localparam int OW = 56;

  typedef struct packed {
    logic        mode;
    logic [15:0] i;
    logic [15:0] j;
    logic [15:0] k;
    logic [15:0] lead;
    logic [31:0] plane;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd3,     16'd5,     16'd0, 16'd1,     32'd0,  64'd156},   // R3
    '{1'b0, 16'd6,     16'd5,     16'd0, 16'd1,     32'd0,  64'd216},   // R3
    '{1'b0, 16'd0,     16'd0,     16'd0, 16'd1,     32'd0,  64'd0},     // R3
    '{1'b0, 16'd7,     16'd7,     16'd0, 16'd1,     32'd0,  64'd252},   // R5
    '{1'b0, 16'd8,     16'd0,     16'd0, 16'd4,     32'd0,  64'd256},   // R6
    '{1'b0, 16'd0,     16'd8,     16'd0, 16'd4,     32'd0,  64'd1024},  // R6
    '{1'b0, 16'd9,     16'd17,    16'd5, 16'd10,    32'd99, 64'd5388},  // R8
    '{1'b1, 16'd1,     16'd0,     16'd0, 16'd1,     32'd1,  64'd4},     // R4
    '{1'b1, 16'd0,     16'd1,     16'd0, 16'd1,     32'd1,  64'd8},     // R4
    '{1'b1, 16'd0,     16'd0,     16'd1, 16'd1,     32'd1,  64'd16},    // R4
    '{1'b1, 16'd3,     16'd3,     16'd3, 16'd1,     32'd1,  64'd252},   // R4
    '{1'b1, 16'd4,     16'd0,     16'd0, 16'd3,     32'd12, 64'd256},   // R7
    '{1'b1, 16'd0,     16'd4,     16'd0, 16'd3,     32'd12, 64'd768},   // R7
    '{1'b1, 16'd0,     16'd0,     16'd4, 16'd3,     32'd12, 64'd3072},  // R7
    '{1'b1, 16'd5,     16'd6,     16'd7, 16'd2,     32'd6,  64'd2516},  // R7
    '{1'b0, 16'hFFFF,  16'hFFFF,  16'd0, 16'hFFFF,  32'd0,  64'd137422176508} // R6
  };

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          dim_sel;
  logic [15:0]   idx_i, idx_j, idx_k;
  logic [15:0]   lead_tiles;
  logic [31:0]   plane_tiles;
  logic          out_valid;
  logic [OW-1:0] out_offset;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  hat_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dim_sel(dim_sel),
    .idx_i(idx_i), .idx_j(idx_j), .idx_k(idx_k),
    .lead_tiles(lead_tiles), .plane_tiles(plane_tiles),
    .out_valid(out_valid), .out_offset(out_offset)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Model: tiles of 8x8 (2-D) or 4x4x4 (3-D), 4-byte elements, 256-byte tiles.
  function automatic logic [63:0] ref_off(input vec_t v);
    int          tb;
    int          na;
    logic [63:0] m, lin;
    logic [15:0] ax [3];
    tb = v.mode ? 2 : 3;
    na = v.mode ? 3 : 2;
    ax[0] = v.i; ax[1] = v.j; ax[2] = v.k;
    m = 0;
    for (int b = 0; b < tb; b++)
      for (int a = 0; a < na; a++)
        if (ax[a][b]) m = m | (64'd1 << (b * na + a));
    lin = 64'(v.i >> tb) + 64'(v.lead) * 64'(v.j >> tb);
    if (v.mode) lin = lin + 64'(v.plane) * 64'(v.k >> tb);
    return (lin << 8) + (m << 2);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    in_valid    = vld;
    dim_sel     = v.mode;
    idx_i       = v.i;
    idx_j       = v.j;
    idx_k       = v.k;
    lead_tiles  = v.lead;
    plane_tiles = v.plane;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  vec_t rv [2];
  vec_t stream [64];
  vec_t zero_v;

  initial begin
    zero_v = '0;
    rst_n  = 1'b0;
    drive(zero_v, 1'b0);

    // R1: reset state, even with a request presented during reset.
    repeat (3) @(posedge clk);
    drive(VECS[0], 1'b1);
    @(negedge clk);
    chk("R1 valid in reset", 64'(out_valid), 64'd0);
    chk("R1 offset in reset", 64'(out_offset), 64'd0);
    drive(zero_v, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after release", 64'(out_valid), 64'd0);

    // Table walk, back-to-back (R10); results checked two edges after drive.
    for (int n = 0; n < NV + 2; n++) begin
      @(negedge clk);
      if (n >= 2) begin
        chk("R10 table valid", 64'(out_valid), 64'd1);
        chk($sformatf("R3/R4/R6/R7 table %0d", n - 2), 64'(out_offset), VECS[n - 2].exp);
        if (ref_off(VECS[n - 2]) !== VECS[n - 2].exp)
          $display("note: model disagrees on table entry %0d", n - 2);
      end
      if (n < NV) drive(VECS[n], 1'b1);
      else        drive(zero_v, 1'b0);
    end

    // R9 and R8: idle with changing inputs leaves the output alone.
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk("R2 idle valid", 64'(out_valid), 64'd0);
      chk("R9 offset held", 64'(out_offset), VECS[NV - 1].exp);
      drive(VECS[n + 3], 1'b0);
    end

    // R8: in 2-D mode, idx_k and plane_tiles have no effect.
    begin
      vec_t a, b;
      a = VECS[0]; a.k = 16'hBEEF; a.plane = 32'hDEADBEEF;
      b = VECS[5]; b.k = 16'h1234; b.plane = 32'hFFFFFFFF;
      @(negedge clk); drive(a, 1'b1);
      @(negedge clk); drive(b, 1'b1);
      @(negedge clk); drive(zero_v, 1'b0);
      chk("R8 k ignored a", 64'(out_offset), 64'd156);
      @(negedge clk);
      chk("R8 plane ignored b", 64'(out_offset), 64'd1024);
    end

    // R2: single isolated pulse, timing on both sides.
    repeat (3) @(negedge clk);
    drive(VECS[14], 1'b1);
    @(negedge clk); drive(zero_v, 1'b0);
    chk("R2 not before second edge", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R2 valid on second edge", 64'(out_valid), 64'd1);
    chk("R2 pulse offset", 64'(out_offset), 64'd2516);
    @(negedge clk);
    chk("R2 single cycle", 64'(out_valid), 64'd0);

    // Random streams in both modes against the model.
    void'($urandom(32'd7));
    for (int blk = 0; blk < 8; blk++) begin
      for (int s = 0; s < 64; s++) begin
        stream[s].mode  = blk[0];
        stream[s].i     = 16'($urandom);
        stream[s].j     = 16'($urandom);
        stream[s].k     = 16'($urandom);
        stream[s].lead  = 16'($urandom);
        stream[s].plane = $urandom;
        stream[s].exp   = '0;
        if (s % 16 == 0) begin
          stream[s].i = 16'($urandom_range(0, 15));
          stream[s].j = 16'($urandom_range(0, 15));
        end
      end
      for (int n = 0; n < 66; n++) begin
        @(negedge clk);
        if (n >= 2) begin
          chk("R10 random valid", 64'(out_valid), 64'd1);
          chk(blk[0] ? "R4/R7 random 3-D" : "R3/R6 random 2-D",
              64'(out_offset), ref_off(stream[n - 2]));
        end
        if (n < 64) drive(stream[n], 1'b1);
        else        drive(zero_v, 1'b0);
      end
    end

    // R1: reset mid-stream clears the valid at once.
    @(negedge clk); drive(VECS[1], 1'b1);
    @(negedge clk); drive(VECS[2], 1'b1);
    #1 rst_n = 1'b0;
    #1 chk("R1 async clear", 64'(out_valid), 64'd0);
    chk("R1 async offset", 64'(out_offset), 64'd0);
    drive(zero_v, 1'b0);
    rv[0] = zero_v; rv[1] = zero_v;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 quiet after reset", 64'(out_valid), 64'd0);

    finish_run();
  end

endmodule